// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

This block is a purely combinational integer ALU for a datapath. It takes two `WIDTH`-bit operands and a 4-bit control word. It returns a result word and three flags: a zero flag, a signed overflow flag and the adder carry-out.

The datapath is a row of one-bit slices, built explicitly by a generate loop. Every slice can invert either operand, compute the AND, the OR and a full-adder sum, and choose one of these or a shared "less" input. Carries ripple from bit 0 to the top. The top slice also produces the comparison bit and the overflow flag. The comparison bit is routed back to the "less" input of bit 0, which is how set-on-less-than is formed.

The control word is split into three fields. Bit 3 inverts operand a. Bit 2 inverts operand b and also supplies the carry into bit 0. Bits 1:0 pick the slice output. Results appear in the same cycle as the inputs; nothing is registered.

Top module: `rc_alu`

## Requirements
- R1: Control 4'b0000 gives `result = a & b` and control 4'b0001 gives `result = a | b`.
- R2: Control 4'b0010 gives `result = a + b`, taken modulo 2^WIDTH.
- R3: Control 4'b0110 gives `result = a - b`, taken modulo 2^WIDTH. It is formed as a + ~b + 1.
- R4: Control 4'b1100 gives `result = ~(a | b)`.
- R5: Control 4'b0111 gives a result whose bit 0 is 1 exactly when a < b as signed two's-complement values, and whose other bits are 0. This holds even when a - b overflows.
- R6: `zero` is 1 exactly when every bit of `result` is 0.
- R7: `overflow` is 1 exactly when the control is 4'b0010 or 4'b0110 and the signed result does not fit in WIDTH bits. For every other control value it is 0.
- R8: Any control value other than the six listed in R1 to R5 gives `result = 0` and `overflow = 0`.
- R9: For every control value, `carry_out` is the carry out of the top bit of A + B + c. Here A is `a` inverted when control bit 3 is set, B is `b` inverted when control bit 2 is set, and c equals control bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| alu_ctl | input | 4 | Control word: bit 3 inverts a; bit 2 inverts b and sets carry-in; bits 1:0 pick AND, OR, sum or less |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
Every output is due zero cycles after its inputs change, because the block has no registers. Only the ripple through the slices and the feedback into bit 0 must settle. The bench therefore drives a new control word and new operands on the falling clock edge. It samples all four outputs a few nanoseconds later, well before the next edge, so each check sees the settled value of that one stimulus. Expected values come from a word-level model in the bench, not from a slice-by-slice copy.

// File: rtl/alu_pkg.sv
// Package alu_pkg
// Shared control encodings and the slice output selector for the
// ripple-carry ALU. Assumes a 4-bit control word whose bit 3 inverts a,
// bit 2 inverts b (and drives carry-in), and bits 1:0 choose the output.
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'd0,
        SEL_OR   = 2'd1,
        SEL_SUM  = 2'd2,
        SEL_LESS = 2'd3
    } slice_sel_e;

    localparam int unsigned CTL_W = 4;

    localparam logic [CTL_W-1:0] CTL_AND = 4'b0000;
    localparam logic [CTL_W-1:0] CTL_OR  = 4'b0001;
    localparam logic [CTL_W-1:0] CTL_ADD = 4'b0010;
    localparam logic [CTL_W-1:0] CTL_SUB = 4'b0110;
    localparam logic [CTL_W-1:0] CTL_SLT = 4'b0111;
    localparam logic [CTL_W-1:0] CTL_NOR = 4'b1100;

    // True for the six supported control codes only.
    function automatic logic ctl_is_valid(input logic [CTL_W-1:0] ctl);
        return (ctl == CTL_AND) || (ctl == CTL_OR)  || (ctl == CTL_ADD) ||
               (ctl == CTL_SUB) || (ctl == CTL_SLT) || (ctl == CTL_NOR);
    endfunction

endpackage

// File: rtl/alu_slice.sv
// Module alu_slice
// One ordinary bit of the ALU. It optionally inverts each operand bit,
// forms AND, OR and a full-adder sum, and picks one of them or the
// shared less input. Assumes carry-in comes from the slice below.
module alu_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       inv_a,
    input  logic       inv_b,
    input  logic       carry_in,
    input  logic       less_in,
    input  slice_sel_e sel,
    output logic       res_bit,
    output logic       carry_out
);

    logic a_eff;
    logic b_eff;
    logic sum_bit;

    // Operand inversion muxes.
    always_comb begin
        a_eff = inv_a ? ~a_bit : a_bit;
        b_eff = inv_b ? ~b_bit : b_bit;
    end

    // Full adder: odd parity for sum, majority for carry.
    always_comb begin
        sum_bit   = a_eff ^ b_eff ^ carry_in;
        carry_out = (b_eff & carry_in) | (a_eff & carry_in) | (a_eff & b_eff);
    end

    // Four-way output selector.
    always_comb begin
        unique case (sel)
            SEL_AND:  res_bit = a_eff & b_eff;
            SEL_OR:   res_bit = a_eff | b_eff;
            SEL_SUM:  res_bit = sum_bit;
            SEL_LESS: res_bit = less_in;
            default:  res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_msb_slice.sv
// Module alu_msb_slice
// The most significant bit of the ALU. It behaves like alu_slice and
// additionally reports signed overflow and the signed less-than bit.
// Assumes its carry-in is the carry out of the bit below.
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       inv_a,
    input  logic       inv_b,
    input  logic       carry_in,
    input  logic       less_in,
    input  slice_sel_e sel,
    output logic       res_bit,
    output logic       carry_out,
    output logic       set_out,
    output logic       ovf_out
);

    logic a_eff;
    logic b_eff;
    logic sum_bit;

    // Operand inversion muxes.
    always_comb begin
        a_eff = inv_a ? ~a_bit : a_bit;
        b_eff = inv_b ? ~b_bit : b_bit;
    end

    // Full adder for the top bit.
    always_comb begin
        sum_bit   = a_eff ^ b_eff ^ carry_in;
        carry_out = (b_eff & carry_in) | (a_eff & carry_in) | (a_eff & b_eff);
    end

    // Overflow: carry into the top bit differs from carry out of it.
    always_comb begin
        ovf_out = carry_in ^ carry_out;
    end

    // Signed less-than: sign of the difference corrected by overflow.
    always_comb begin
        set_out = sum_bit ^ ovf_out;
    end

    // Four-way output selector.
    always_comb begin
        unique case (sel)
            SEL_AND:  res_bit = a_eff & b_eff;
            SEL_OR:   res_bit = a_eff | b_eff;
            SEL_SUM:  res_bit = sum_bit;
            SEL_LESS: res_bit = less_in;
            default:  res_bit = 1'b0;
        endcase
    end

    // Overflow can only arise from like-signed addends giving an unlike-signed sum.
    always_comb begin
        if (ovf_out) begin
            AST_OVF_SIGNS: assert ((a_eff == b_eff) && (sum_bit != a_eff)); // R7
        end
    end

endmodule

// File: rtl/alu_zero_detect.sv
// Module alu_zero_detect
// Reduces a result word to a single flag that is high when every bit is
// clear. Assumes a result word of WIDTH bits.
module alu_zero_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    output logic             all_clear
);

    // NOR of all result bits.
    always_comb begin
        all_clear = ~(|word);
    end

endmodule

// File: rtl/rc_alu.sv
// Module rc_alu
// Combinational ALU built from a generated chain of one-bit slices with
// a dedicated top slice. Carries ripple upward, and the top slice's
// less-than bit feeds back into bit 0 for set-on-less-than. Unsupported
// control codes yield a zero result. Assumes WIDTH >= 2.
module rc_alu
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [3:0]       alu_ctl,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             overflow,
    output logic             carry_out
);

    localparam int unsigned MSB = WIDTH - 1;

    logic             inv_a;
    logic             neg_b;
    slice_sel_e       sel;
    logic             ctl_ok;
    logic             set_w;
    logic             ovf_raw;
    logic             top_carry;
    logic [WIDTH-1:0] res_raw;

    // Split the control word into its fields.
    always_comb begin
        inv_a  = alu_ctl[3];
        neg_b  = alu_ctl[2];
        sel    = slice_sel_e'(alu_ctl[1:0]);
        ctl_ok = ctl_is_valid(alu_ctl);
    end

    // Slice chain: each bit takes the carry of the bit below.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic cin_w;
        logic cout_w;

        if (i == 0) begin : g_cin_lsb
            assign cin_w = neg_b;
        end else begin : g_cin_chain
            assign cin_w = g_bit[i-1].cout_w;
        end

        if (i == MSB) begin : g_top
            alu_msb_slice u_slice (
                .a_bit     (a_in[i]),
                .b_bit     (b_in[i]),
                .inv_a     (inv_a),
                .inv_b     (neg_b),
                .carry_in  (cin_w),
                .less_in   (1'b0),
                .sel       (sel),
                .res_bit   (res_raw[i]),
                .carry_out (cout_w),
                .set_out   (set_w),
                .ovf_out   (ovf_raw)
            );
        end else begin : g_mid
            alu_slice u_slice (
                .a_bit     (a_in[i]),
                .b_bit     (b_in[i]),
                .inv_a     (inv_a),
                .inv_b     (neg_b),
                .carry_in  (cin_w),
                .less_in   ((i == 0) ? set_w : 1'b0),
                .sel       (sel),
                .res_bit   (res_raw[i]),
                .carry_out (cout_w)
            );
        end
    end

    assign top_carry = g_bit[MSB].cout_w;

    // Gate the result and flags by code validity and operation kind.
    always_comb begin
        result    = ctl_ok ? res_raw : '0;
        overflow  = ctl_ok && (sel == SEL_SUM) && ovf_raw;
        carry_out = top_carry;
    end

    alu_zero_detect #(
        .WIDTH (WIDTH)
    ) u_zero (
        .word      (result),
        .all_clear (zero)
    );

    // Unsupported codes leave the result and overflow clear.
    always_comb begin
        if (!ctl_is_valid(alu_ctl)) begin
            AST_BAD_CODE_CLEAR: assert ((result == '0) && !overflow); // R8
        end
    end

    // Set-on-less-than fills only bit 0 and follows signed order.
    always_comb begin
        if (alu_ctl == CTL_SLT) begin
            AST_SLT_UPPER_CLEAR: assert (result[MSB:1] == '0); // R5
            AST_SLT_SIGNED: assert (result[0] == ($signed(a_in) < $signed(b_in))); // R5
        end
    end

    // Subtract reports zero exactly on equal operands.
    always_comb begin
        if (alu_ctl == CTL_SUB) begin
            AST_SUB_ZERO_EQ: assert (zero == (a_in == b_in)); // R6
        end
    end

    // Overflow is confined to add and subtract.
    always_comb begin
        if ((alu_ctl != CTL_ADD) && (alu_ctl != CTL_SUB)) begin
            AST_NO_OVERFLOW: assert (!overflow); // R7
        end
    end

endmodule

// File: tb/rc_alu_tb.sv
// Directed bench for rc_alu: one task per scenario, each checking the
// four outputs against a word-level model.
module rc_alu_tb;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic [3:0]   alu_ctl;
    logic [W-1:0] result;
    logic         zero;
    logic         overflow;
    logic         carry_out;

    int unsigned n_cmp  = 0;
    int unsigned n_bad  = 0;
    bit          closed = 1'b0;

    always #5 clk = ~clk;

    rc_alu #(.WIDTH(W)) u_dut (
        .a_in      (a_in),
        .b_in      (b_in),
        .alu_ctl   (alu_ctl),
        .result    (result),
        .zero      (zero),
        .overflow  (overflow),
        .carry_out (carry_out)
    );

    // One comparison with its own report line on mismatch.
    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (ctl=%b a=%h b=%h)",
                     tag, got, exp, alu_ctl, a_in, b_in);
        end
    endtask

    // Drive one stimulus on the falling edge, check shortly after.
    task automatic apply(input logic [3:0] ctl, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] ae, be, sum, exp_res;
        logic [W:0]   wide;
        logic         exp_ovf, exp_cout;
        string        tag;
        @(negedge clk);
        alu_ctl = ctl;
        a_in    = a;
        b_in    = b;
        ae   = ctl[3] ? ~a : a;
        be   = ctl[2] ? ~b : b;
        wide = {1'b0, ae} + {1'b0, be} + {{W{1'b0}}, ctl[2]};
        sum  = wide[W-1:0];
        exp_cout = wide[W];
        exp_ovf  = 1'b0;
        case (ctl)
            4'b0000: begin exp_res = a & b;       tag = "R1 and"; end
            4'b0001: begin exp_res = a | b;       tag = "R1 or";  end
            4'b0010: begin exp_res = a + b;       tag = "R2 add"; end
            4'b0110: begin exp_res = a - b;       tag = "R3 sub"; end
            4'b1100: begin exp_res = ~(a | b);    tag = "R4 nor"; end
            4'b0111: begin
                exp_res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
                tag = "R5 slt";
            end
            default: begin exp_res = '0;          tag = "R8 invalid"; end
        endcase
        if (ctl == 4'b0010) exp_ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        if (ctl == 4'b0110) exp_ovf = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
        #3;
        chk(tag, result, exp_res);
        chk("R6 zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (exp_res == '0)});
        chk("R7 overflow", {{(W-1){1'b0}}, overflow}, {{(W-1){1'b0}}, exp_ovf});
        chk("R9 carry", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, exp_cout});
    endtask

    // Idle state: all-zero inputs give zero result with zero flag set.
    task automatic t_idle();
        apply(4'b0000, '0, '0);
    endtask

    // R1 and R4: logic operations on patterned and random operands.
    task automatic t_logic();
        apply(4'b0000, 32'hF0F0_F0F0, 32'hFF00_FF00);
        apply(4'b0001, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
        apply(4'b1100, 32'h0000_0000, 32'h0000_0000);
        apply(4'b1100, 32'hFFFF_FFFF, 32'h1234_5678);
        for (int k = 0; k < 200; k++) begin
            apply(4'b0000, $urandom, $urandom);
            apply(4'b0001, $urandom, $urandom);
            apply(4'b1100, $urandom, $urandom);
        end
    endtask

    // R2, R3, R7, R9: arithmetic with carries and signed overflow.
    task automatic t_arith();
        apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
        apply(4'b0010, 32'h8000_0000, 32'h8000_0000);
        apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(4'b0110, 32'h8000_0000, 32'h0000_0001);
        apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply(4'b0110, 32'h0000_0000, 32'h0000_0001);
        for (int k = 0; k < 300; k++) begin
            apply(4'b0010, $urandom, $urandom);
            apply(4'b0110, $urandom, $urandom);
        end
    endtask

    // R5: signed compare including overflowing differences.
    task automatic t_slt();
        apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
        apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
        apply(4'b0111, 32'h0000_0005, 32'h0000_0005);
        apply(4'b0111, 32'h8000_0000, 32'h0000_0001);
        for (int k = 0; k < 300; k++) apply(4'b0111, $urandom, $urandom);
    endtask

    // R6: equal operands and cancelling sums give the zero flag.
    task automatic t_zero();
        apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        apply(4'b0010, 32'h0000_0001, 32'hFFFF_FFFF);
        apply(4'b0000, 32'hAAAA_AAAA, 32'h5555_5555);
        apply(4'b0110, 32'h8000_0000, 32'h8000_0000);
    endtask

    // R8: every unsupported code, with operands that would give nonzero results.
    task automatic t_invalid();
        for (int c = 0; c < 16; c++) begin
            apply(4'(c), 32'hFFFF_FFFF, 32'h0000_0001);
            apply(4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
            apply(4'(c), $urandom, $urandom);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        if (!closed) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        alu_ctl = 4'b0000;
        a_in    = '0;
        b_in    = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_logic();
        t_arith();
        t_slt();
        t_zero();
        t_invalid();
        closed = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule